// File: doc/BRIEF.md
# Prefixed Byte-Enabled Integer Register File

This block holds the integer architectural state: 128 entries of 64 bits, each entry kept as a low and a high 32-bit bank. Operands are named by a 5-bit index plus a prefix bit. With the prefix clear the index picks one of the scalar entries 0 to 31. With the prefix set the index is scaled by four, so the block reaches the vector-aligned entries 0, 4, ... 124. Entries above 31 that are not multiples of four cannot be reached through these ports.

Each port carries a 2-bit element-width code that sets how many low-order bytes take part in the access. A read returns those bytes right-justified, with all bytes above them at zero. A write drives per-byte write enables sized from the width, so bytes above the element keep their contents. The high bank is only enabled for full 64-bit writes. Entry 0 always reads as zero and ignores writes. There are two combinational read ports and one write port that commits on the rising clock edge. The ports are random-access register-file ports, not streams: there is no valid/ready handshake and no back-pressure, and a write is taken whenever the write enable is high at a clock edge.

Top module: `prefixed_rf`

## Requirements
- R1: With prefix 0, index i (0..31) addresses physical entry i.
- R2: With prefix 1, index i addresses physical entry 4*i, so vector index k and scalar index 4*k name the same storage when 4*k < 32.
- R3: Physical entry 0 reads as all zeros on both read ports, whichever prefix names it, and a write to it is discarded.
- R4: Width code 2'b00 reads 8 bytes, 2'b01 reads 1 byte, 2'b10 reads 2 bytes and 2'b11 reads 4 bytes. The result is the low bytes of the entry, right-justified, with every byte above them driven to zero.
- R5: A write with width code 2'b01, 2'b10, 2'b11 or 2'b00 updates only the low 1, 2, 4 or 8 bytes of the entry. Every other byte keeps its previous value.
- R6: A write takes effect at the rising clock edge after it is presented. A read of the same entry in the same cycle returns the old contents.
- R7: The two read ports are independent: each uses its own prefix, index and width in the same cycle.
- R8: After an active-low reset every entry reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all entries |
| rd0_pfx | input | 1 | Read port 0 prefix (1 = vector-scaled index) |
| rd0_idx | input | 5 | Read port 0 register index |
| rd0_ew | input | 2 | Read port 0 element-width code |
| rd0_data | output | 64 | Read port 0 data, right-justified and zero-padded |
| rd1_pfx | input | 1 | Read port 1 prefix |
| rd1_idx | input | 5 | Read port 1 register index |
| rd1_ew | input | 2 | Read port 1 element-width code |
| rd1_data | output | 64 | Read port 1 data |
| wr_en | input | 1 | Write enable |
| wr_pfx | input | 1 | Write prefix |
| wr_idx | input | 5 | Write register index |
| wr_ew | input | 2 | Write element-width code |
| wr_data | input | 64 | Write data; only the low element bytes are used |

## Verification
After reset, every scalar and vector address is swept on both ports to show that storage starts cleared. Directed cycles then cover four cases. A narrow write over a full-width value shows that the upper bytes are kept, which a whole-entry write would clobber. A vector write read back through the aliasing scalar index tells the scaled mapping apart from the direct one. A read of the address being written in the same cycle tells the write-first and read-first orderings apart. Two ports read at different widths in one cycle to expose any shared decode. A long random mix of prefixes, indices, widths and writes, with index 0 drawn often, is then compared against a byte-level model on every clock.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic [1:0] {
    EW_64 = 2'b00,
    EW_8  = 2'b01,
    EW_16 = 2'b10,
    EW_32 = 2'b11
  } ew_e;
endpackage

// File: rtl/rf_addr_map.sv
module rf_addr_map #(
  parameter int IDX_W     = 5,
  parameter int VEC_SHIFT = 2,
  localparam int ENT_W    = IDX_W + VEC_SHIFT
) (
  input  logic             pfx,
  input  logic [IDX_W-1:0] idx,
  output logic [ENT_W-1:0] ent,
  output logic             is_zero
);
  always_comb begin
    if (pfx) ent = {idx, {VEC_SHIFT{1'b0}}};
    else     ent = {{VEC_SHIFT{1'b0}}, idx};
  end
  assign is_zero = (ent == '0);
endmodule

// File: rtl/rf_width_mask.sv
module rf_width_mask #(
  parameter int N_BYTES = 8
) (
  input  rf_pkg::ew_e        ew,
  output logic [N_BYTES-1:0] be
);
  int unsigned nbytes;
  always_comb begin
    unique case (ew)
      rf_pkg::EW_8:  nbytes = 1;
      rf_pkg::EW_16: nbytes = 2;
      rf_pkg::EW_32: nbytes = 4;
      default:       nbytes = N_BYTES;
    endcase
  end
  for (genvar b = 0; b < N_BYTES; b++) begin : g_be
    assign be[b] = (b < nbytes);
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int N_ENT      = 128,
  parameter int BANK_BYTES = 4,
  localparam int ENT_W     = $clog2(N_ENT),
  localparam int BW        = BANK_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BANK_BYTES-1:0] wbe,
  input  logic [ENT_W-1:0]      wa,
  input  logic [BW-1:0]         wd,
  input  logic [ENT_W-1:0]      ra0,
  output logic [BW-1:0]         rd0,
  input  logic [ENT_W-1:0]      ra1,
  output logic [BW-1:0]         rd1
);
  logic [BW-1:0] mem [N_ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENT; e++) mem[e] <= '0;
    end else begin
      for (int b = 0; b < BANK_BYTES; b++) begin
        if (wbe[b]) mem[wa][b*8 +: 8] <= wd[b*8 +: 8];
      end
    end
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
endmodule

// File: rtl/prefixed_rf.sv
module prefixed_rf #(
  parameter int IDX_W     = 5,
  parameter int VEC_SHIFT = 2,
  parameter int DATA_W    = 64,
  parameter int BANK_W    = 32,
  localparam int ENT_W    = IDX_W + VEC_SHIFT,
  localparam int N_ENT    = 1 << ENT_W,
  localparam int N_BYTES  = DATA_W / 8,
  localparam int N_BANKS  = DATA_W / BANK_W,
  localparam int BANK_B   = BANK_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd0_pfx,
  input  logic [IDX_W-1:0]  rd0_idx,
  input  logic [1:0]        rd0_ew,
  output logic [DATA_W-1:0] rd0_data,
  input  logic              rd1_pfx,
  input  logic [IDX_W-1:0]  rd1_idx,
  input  logic [1:0]        rd1_ew,
  output logic [DATA_W-1:0] rd1_data,
  input  logic              wr_en,
  input  logic              wr_pfx,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_ew,
  input  logic [DATA_W-1:0] wr_data
);
  logic [ENT_W-1:0]   ent_r0, ent_r1, ent_w;
  logic               zero_r0, zero_r1, zero_w;
  logic [N_BYTES-1:0] be_r0, be_r1, be_w, be_wq;
  logic [DATA_W-1:0]  raw0, raw1;

  rf_addr_map #(.IDX_W(IDX_W), .VEC_SHIFT(VEC_SHIFT)) u_map_r0 (
    .pfx(rd0_pfx), .idx(rd0_idx), .ent(ent_r0), .is_zero(zero_r0));
  rf_addr_map #(.IDX_W(IDX_W), .VEC_SHIFT(VEC_SHIFT)) u_map_r1 (
    .pfx(rd1_pfx), .idx(rd1_idx), .ent(ent_r1), .is_zero(zero_r1));
  rf_addr_map #(.IDX_W(IDX_W), .VEC_SHIFT(VEC_SHIFT)) u_map_w (
    .pfx(wr_pfx), .idx(wr_idx), .ent(ent_w), .is_zero(zero_w));

  rf_width_mask #(.N_BYTES(N_BYTES)) u_msk_r0 (.ew(rf_pkg::ew_e'(rd0_ew)), .be(be_r0));
  rf_width_mask #(.N_BYTES(N_BYTES)) u_msk_r1 (.ew(rf_pkg::ew_e'(rd1_ew)), .be(be_r1));
  rf_width_mask #(.N_BYTES(N_BYTES)) u_msk_w  (.ew(rf_pkg::ew_e'(wr_ew)),  .be(be_w));

  // writes to the hard-wired zero entry are dropped before reaching storage
  assign be_wq = (wr_en && !zero_w) ? be_w : '0;

  for (genvar k = 0; k < N_BANKS; k++) begin : g_bank
    rf_bank #(.N_ENT(N_ENT), .BANK_BYTES(BANK_B)) u_bank (
      .clk (clk),
      .rst_n(rst_n),
      .wbe (be_wq[k*BANK_B +: BANK_B]),
      .wa  (ent_w),
      .wd  (wr_data[k*BANK_W +: BANK_W]),
      .ra0 (ent_r0),
      .rd0 (raw0[k*BANK_W +: BANK_W]),
      .ra1 (ent_r1),
      .rd1 (raw1[k*BANK_W +: BANK_W])
    );
  end

  for (genvar b = 0; b < N_BYTES; b++) begin : g_rdmask
    assign rd0_data[b*8 +: 8] = (be_r0[b] && !zero_r0) ? raw0[b*8 +: 8] : 8'h00;
    assign rd1_data[b*8 +: 8] = (be_r1[b] && !zero_r1) ? raw1[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/prefixed_rf_chk.sv
module prefixed_rf_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd0_pfx,
  input logic [4:0]  rd0_idx,
  input logic [1:0]  rd0_ew,
  input logic [63:0] rd0_data,
  input logic        rd1_pfx,
  input logic [4:0]  rd1_idx,
  input logic [1:0]  rd1_ew,
  input logic [63:0] rd1_data,
  input logic        wr_en,
  input logic        wr_pfx,
  input logic [4:0]  wr_idx,
  input logic [1:0]  wr_ew,
  input logic [63:0] wr_data
);
  AST_ZERO_RD0: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_idx == 5'd0) |-> (rd0_data == 64'd0)); // R3
  AST_ZERO_RD1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_idx == 5'd0) |-> (rd1_data == 64'd0)); // R3
  AST_BYTE_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_ew == 2'b01) |-> (rd0_data[63:8] == 56'd0)); // R4
  AST_HALF_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_ew == 2'b11) |-> (rd1_data[63:32] == 32'd0)); // R4
  AST_NARROW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ew == 2'b01 && wr_pfx == rd0_pfx && wr_idx == rd0_idx && rd0_ew == 2'b00)
    |=> (($stable(rd0_pfx) && $stable(rd0_idx) && rd0_ew == 2'b00)
         |-> (rd0_data[63:8] == $past(rd0_data[63:8])))); // R5
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ew == 2'b00 && wr_idx != 5'd0 && wr_pfx == rd1_pfx && wr_idx == rd1_idx)
    |=> (($stable(rd1_pfx) && $stable(rd1_idx) && rd1_ew == 2'b00)
         |-> (rd1_data == $past(wr_data)))); // R6
endmodule

bind prefixed_rf prefixed_rf_chk u_chk (.*);

// File: tb/test_prefixed_rf.sv
module test_prefixed_rf;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd0_pfx = 0, rd1_pfx = 0, wr_en = 0, wr_pfx = 0;
  logic [4:0]  rd0_idx = 0, rd1_idx = 0, wr_idx = 0;
  logic [1:0]  rd0_ew = 0, rd1_ew = 0, wr_ew = 0;
  logic [63:0] wr_data = 0;
  logic [63:0] rd0_data, rd1_data;

  int n_tests = 0;
  int n_fail  = 0;
  logic [63:0] model [128];

  always #(CLK_P/2) clk = ~clk;

  prefixed_rf i_prefixed_rf (.*);

  function automatic int ent_of(logic p, logic [4:0] i);
    return p ? int'(i) * 4 : int'(i);
  endfunction

  function automatic int bytes_of(logic [1:0] e);
    case (e)
      2'b01: return 1;
      2'b10: return 2;
      2'b11: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic logic [63:0] expect_rd(logic p, logic [4:0] i, logic [1:0] e);
    logic [63:0] v = 64'd0;
    int n = ent_of(p, i);
    if (n == 0) return 64'd0;
    for (int b = 0; b < bytes_of(e); b++) v[b*8 +: 8] = model[n][b*8 +: 8];
    return v;
  endfunction

  function automatic string auto_tag(logic p, logic [4:0] i, logic [1:0] e);
    if (ent_of(p, i) == 0) return "R3";
    if (e != 2'b00) return "R4";
    return p ? "R2" : "R1";
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock cycle: drive, check reads at negedge, commit model at posedge
  task automatic cyc(logic we, logic wp, logic [4:0] wi, logic [1:0] we_w, logic [63:0] wd,
                     logic p0, logic [4:0] i0, logic [1:0] e0,
                     logic p1, logic [4:0] i1, logic [1:0] e1, string tag);
    wr_en = we; wr_pfx = wp; wr_idx = wi; wr_ew = we_w; wr_data = wd;
    rd0_pfx = p0; rd0_idx = i0; rd0_ew = e0;
    rd1_pfx = p1; rd1_idx = i1; rd1_ew = e1;
    @(negedge clk);
    check(tag != "" ? tag : auto_tag(p0, i0, e0), rd0_data, expect_rd(p0, i0, e0));
    check(tag != "" ? tag : auto_tag(p1, i1, e1), rd1_data, expect_rd(p1, i1, e1));
    @(posedge clk);
    if (we && ent_of(wp, wi) != 0)
      for (int b = 0; b < bytes_of(we_w); b++) model[ent_of(wp, wi)][b*8 +: 8] = wd[b*8 +: 8];
    #1;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int e = 0; e < 128; e++) model[e] = 64'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R8: all reachable entries clear after reset
    for (int i = 0; i < 32; i++)
      cyc(0, 0, 0, 0, 0, 0, 5'(i), 2'b00, 1, 5'(i), 2'b00, "R8");

    // R5: narrow write over a full value keeps upper bytes
    cyc(1, 0, 5, 2'b00, 64'h0123_4567_89AB_CDEF, 0, 0, 0, 0, 0, 0, "");
    cyc(1, 0, 5, 2'b01, 64'hFFFF_FFFF_FFFF_FF11, 0, 5, 2'b00, 0, 5, 2'b00, "R5");
    cyc(0, 0, 0, 0, 0, 0, 5, 2'b00, 0, 5, 2'b10, "R5");
    cyc(1, 0, 5, 2'b11, 64'hAAAA_AAAA_2233_4455, 0, 5, 2'b00, 0, 5, 2'b00, "R5");
    cyc(0, 0, 0, 0, 0, 0, 5, 2'b00, 0, 5, 2'b01, "R5");

    // R2: vector index 3 aliases scalar 12
    cyc(1, 1, 3, 2'b00, 64'hDEAD_BEEF_CAFE_F00D, 0, 12, 2'b00, 1, 3, 2'b00, "R6");
    cyc(0, 0, 0, 0, 0, 0, 12, 2'b00, 1, 3, 2'b00, "R2");
    cyc(1, 1, 20, 2'b00, 64'h1111_2222_3333_4444, 1, 20, 2'b00, 1, 20, 2'b11, "R6");
    cyc(0, 0, 0, 0, 0, 1, 20, 2'b00, 0, 20, 2'b00, "R2");

    // R3: entry 0 writes are dropped, reads zero
    cyc(1, 0, 0, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 2'b00, 1, 0, 2'b00, "R3");
    cyc(1, 1, 0, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 2'b00, 1, 0, 2'b00, "R3");
    cyc(0, 0, 0, 0, 0, 0, 0, 2'b00, 1, 0, 2'b01, "R3");

    // R7: two ports, different entries and widths
    cyc(1, 0, 7, 2'b00, 64'h8877_6655_4433_2211, 0, 5, 2'b00, 0, 12, 2'b00, "R7");
    cyc(0, 0, 0, 0, 0, 0, 7, 2'b01, 0, 12, 2'b11, "R7");
    cyc(0, 0, 0, 0, 0, 0, 12, 2'b10, 0, 7, 2'b00, "R7");

    // R1/R4/R6 random mix against the model
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] wi = ($urandom_range(0, 7) == 0) ? 5'd0 : 5'($urandom);
      logic [4:0] i0 = ($urandom_range(0, 7) == 0) ? 5'd0 : 5'($urandom);
      logic [4:0] i1 = ($urandom_range(0, 3) == 0) ? wi : 5'($urandom);
      cyc(1'($urandom), 1'($urandom), wi, 2'($urandom), {$urandom, $urandom},
          1'($urandom), i0, 2'($urandom), 1'($urandom), i1, 2'($urandom), "");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule